// File: doc/BRIEF.md
# Stream Frame Sequence-Number Handler

This block sits between a pair of host-side streams and a pair of link-side streams. Each frame may carry a sequence number as its final data word. In the link-to-host direction the block can drop that trailing word, so the host sees only the payload, with the end-of-frame marker moved onto the word before it. In the host-to-link direction it can append a trailing word. That word is either a locally generated count that rises by one per frame, or the sequence number taken from the most recently received frame. A single control bit turns all of this off, and frames then cross unchanged in both directions.

A small register file, reached through a plain address / write-enable / data port, holds the block's state. It gives a registered copy of six link health inputs, a control word, and two 64-bit frame counters, one per direction, each read as two 32-bit halves. Reads are combinational from the address. The block samples the sequence options once per frame, on that frame's first accepted beat, so a control write in the middle of a frame takes effect at the next frame.

Top module: `seq_frame_handler`

## Requirements
- R1: After reset every register offset reads 0, `lnk_loopback` is 0, and neither stream output presents a valid beat while its inputs are idle.
- R2: Offset 0x00 is read-only and returns the link inputs one clock edge after they are driven: bit 0 channel up, bit 1 lane up, bit 2 hard error, bit 3 soft error, bit 4 frame error, bit 5 hot-plug expired. Bits 31..6 read 0.
- R3: Offset 0x04 is read/write. Bit 0 loopback, bit 2 sequence handling off, bit 3 strip and bit 4 echo read back as written. Bit 0 drives `lnk_loopback`.
- R4: Writing 0x04 with bit 1 set clears both frame counters at that write's clock edge. Bit 1 then reads 1 for exactly one cycle and 0 afterwards.
- R5: The incoming counter rises by one for each accepted link-side receive beat that carries the last flag. Its low half is at 0x08 and its high half at 0x0C.
- R6: The outgoing counter rises by one for each accepted link-side transmit beat that carries the last flag, including an appended word. Its high half is at 0x18 and its low half at 0x1C.
- R7: With bit 2 set, frames cross unmodified in both directions, and the strip and echo bits have no effect.
- R8: With bit 2 clear and bit 3 set, the last word of each received frame is withheld from the host, and the host's last flag sits on the word before it. A one-word frame produces no host beat.
- R9: With bit 2 clear and bit 4 clear, each transmitted frame is followed by one extra last word holding a local count. The count is 0 for the first such frame after reset and rises by one per frame.
- R10: With bit 2 clear and bit 4 set, the appended last word equals the final word of the most recent frame received while bit 2 was clear, or 0 if there has been none.
- R11: The sequence options (bits 2, 3, 4) take effect for a frame as sampled on its first accepted beat. A change during the frame applies from the next frame.
- R12: Reads of any offset other than 0x00, 0x04, 0x08, 0x0C, 0x18 and 0x1C return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_in_tdata | input | DATA_W | Host transmit data |
| tx_in_tvalid | input | 1 | Host transmit valid |
| tx_in_tlast | input | 1 | Host transmit end of frame |
| tx_in_tready | output | 1 | Block ready for host transmit beat |
| tx_out_tdata | output | DATA_W | Link transmit data |
| tx_out_tvalid | output | 1 | Link transmit valid |
| tx_out_tlast | output | 1 | Link transmit end of frame |
| tx_out_tready | input | 1 | Link ready for transmit beat |
| rx_in_tdata | input | DATA_W | Link receive data |
| rx_in_tvalid | input | 1 | Link receive valid |
| rx_in_tlast | input | 1 | Link receive end of frame |
| rx_in_tready | output | 1 | Block ready for link receive beat |
| rx_out_tdata | output | DATA_W | Host receive data |
| rx_out_tvalid | output | 1 | Host receive valid |
| rx_out_tlast | output | 1 | Host receive end of frame |
| rx_out_tready | input | 1 | Host ready for receive beat |
| lnk_chan_up | input | 1 | Channel ready indication |
| lnk_lane_up | input | 1 | Lane ready indication |
| lnk_hard_err | input | 1 | Hard error indication |
| lnk_soft_err | input | 1 | Soft error indication |
| lnk_frame_err | input | 1 | Framing error indication |
| lnk_hotplug_exp | input | 1 | Hot-plug timer expired |
| lnk_loopback | output | 1 | Loopback select toward the link |
| reg_addr | input | 5 | Register byte offset |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from address) |

## Verification
The stream paths need no clock edge, except where stripping holds one word back. Each host beat therefore appears in the same cycle as the link beat that follows it, and the frame's last host beat appears with the dropped word. Status bits, control read-back and both counters change at the first clock edge after the stimulus, and the counter-clear flag reads 1 for exactly that one cycle. The bench drives every input just after a falling edge and samples one time unit later. It records a handshake only when valid and ready are both high at that sample, and it reads registers at the falling edge that follows the relevant rising edge. Expected frames, sequence words and counts come from a bench model that tracks the generated count, the last captured sequence word and the frame totals.

// File: rtl/seqh_pkg.sv
package seqh_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 5;
    localparam int CNT_W  = 2 * REG_W;

    localparam logic [ADDR_W-1:0] OFS_STATUS = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_IN_LO  = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_IN_HI  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_OUT_HI = 5'h18;
    localparam logic [ADDR_W-1:0] OFS_OUT_LO = 5'h1C;

    // packed from MSB: echo is bit 4, loopback is bit 0
    typedef struct packed {
        logic echo;
        logic strip;
        logic seq_off;
        logic cnt_clr;
        logic loopback;
    } ctrl_t;

    typedef struct packed {
        logic hotplug_exp;
        logic frame_err;
        logic soft_err;
        logic hard_err;
        logic lane_up;
        logic chan_up;
    } stat_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int STAT_W = $bits(stat_t);
endpackage

// File: rtl/seqh_rx_path.sv
module seqh_rx_path #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_off,
    input  logic              strip,
    input  logic [DATA_W-1:0] in_tdata,
    input  logic              in_tvalid,
    input  logic              in_tlast,
    output logic              in_tready,
    output logic [DATA_W-1:0] out_tdata,
    output logic              out_tvalid,
    output logic              out_tlast,
    input  logic              out_tready,
    output logic              frame_done,
    output logic [DATA_W-1:0] last_seq
);
    typedef struct packed {
        logic              infrm;
        logic              act_strip;
        logic              act_seq;
        logic              hold_v;
        logic [DATA_W-1:0] hold;
        logic [DATA_W-1:0] seq;
    } rx_st_t;

    rx_st_t q, d;
    logic strip_now, seq_now, acc;

    always_comb begin
        strip_now = q.infrm ? q.act_strip : (strip & ~seq_off);
        seq_now   = q.infrm ? q.act_seq   : ~seq_off;

        if (strip_now) begin
            out_tvalid = q.hold_v & in_tvalid;
            out_tdata  = q.hold;
            out_tlast  = in_tlast;
            in_tready  = ~q.hold_v | out_tready;
        end else begin
            out_tvalid = in_tvalid;
            out_tdata  = in_tdata;
            out_tlast  = in_tlast;
            in_tready  = out_tready;
        end

        acc = in_tvalid & in_tready;
        d   = q;
        if (acc) begin
            if (!q.infrm) begin
                d.act_strip = strip_now;
                d.act_seq   = seq_now;
            end
            d.infrm = ~in_tlast;
            if (strip_now) begin
                if (in_tlast) begin
                    d.hold_v = 1'b0;
                end else begin
                    d.hold   = in_tdata;
                    d.hold_v = 1'b1;
                end
            end
            if (in_tlast && seq_now) begin
                d.seq = in_tdata;
            end
        end
        frame_done = acc & in_tlast;
        last_seq   = q.seq;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/seqh_tx_path.sv
module seqh_tx_path #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_off,
    input  logic              echo,
    input  logic [DATA_W-1:0] rx_seq,
    input  logic [DATA_W-1:0] in_tdata,
    input  logic              in_tvalid,
    input  logic              in_tlast,
    output logic              in_tready,
    output logic [DATA_W-1:0] out_tdata,
    output logic              out_tvalid,
    output logic              out_tlast,
    input  logic              out_tready,
    output logic              frame_done
);
    typedef struct packed {
        logic              infrm;
        logic              act_app;
        logic              act_echo;
        logic              app_ph;
        logic [DATA_W-1:0] gen;
    } tx_st_t;

    tx_st_t q, d;
    logic app_now, echo_now;

    always_comb begin
        app_now  = q.infrm ? q.act_app  : ~seq_off;
        echo_now = q.infrm ? q.act_echo : echo;

        if (q.app_ph) begin
            out_tvalid = 1'b1;
            out_tdata  = q.act_echo ? rx_seq : q.gen;
            out_tlast  = 1'b1;
            in_tready  = 1'b0;
        end else begin
            out_tvalid = in_tvalid;
            out_tdata  = in_tdata;
            out_tlast  = in_tlast & ~app_now;
            in_tready  = out_tready;
        end

        d = q;
        if (!q.app_ph && in_tvalid && in_tready) begin
            if (!q.infrm) begin
                d.act_app  = app_now;
                d.act_echo = echo_now;
            end
            d.infrm  = ~in_tlast | app_now;
            d.app_ph = in_tlast & app_now;
        end
        if (q.app_ph && out_tready) begin
            d.app_ph = 1'b0;
            d.infrm  = 1'b0;
            if (!q.act_echo) begin
                d.gen = q.gen + DATA_W'(1);
            end
        end
        frame_done = out_tvalid & out_tready & out_tlast;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/seqh_regs.sv
module seqh_regs
    import seqh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  stat_t             stat_in,
    input  logic              frame_in,
    input  logic              frame_out,
    output ctrl_t             ctrl,
    output stat_t             stat_q,
    output logic [CNT_W-1:0]  cnt_in,
    output logic [CNT_W-1:0]  cnt_out
);
    typedef struct packed {
        ctrl_t             ctrl;
        stat_t             stat;
        logic [CNT_W-1:0]  cin;
        logic [CNT_W-1:0]  cout;
    } regs_st_t;

    regs_st_t q, d;
    logic ctrl_wr, clr_now;
    logic wdata_unused;

    assign wdata_unused = ^reg_wdata[REG_W-1:CTRL_W];

    always_comb begin
        ctrl_wr = reg_wen && (reg_addr == OFS_CTRL);
        clr_now = ctrl_wr && reg_wdata[1];

        d = q;
        d.stat = stat_in;
        d.ctrl.cnt_clr = 1'b0;
        if (ctrl_wr) begin
            d.ctrl = ctrl_t'(reg_wdata[CTRL_W-1:0]);
        end

        if (clr_now) begin
            d.cin  = '0;
            d.cout = '0;
        end else begin
            if (frame_in)  d.cin  = q.cin  + CNT_W'(1);
            if (frame_out) d.cout = q.cout + CNT_W'(1);
        end

        case (reg_addr)
            OFS_STATUS: reg_rdata = REG_W'(q.stat);
            OFS_CTRL:   reg_rdata = REG_W'(q.ctrl);
            OFS_IN_LO:  reg_rdata = q.cin[REG_W-1:0];
            OFS_IN_HI:  reg_rdata = q.cin[CNT_W-1:REG_W];
            OFS_OUT_HI: reg_rdata = q.cout[CNT_W-1:REG_W];
            OFS_OUT_LO: reg_rdata = q.cout[REG_W-1:0];
            default:    reg_rdata = '0;
        endcase

        ctrl    = q.ctrl;
        stat_q  = q.stat;
        cnt_in  = q.cin;
        cnt_out = q.cout;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/seq_frame_handler.sv
module seq_frame_handler
    import seqh_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] tx_in_tdata,
    input  logic              tx_in_tvalid,
    input  logic              tx_in_tlast,
    output logic              tx_in_tready,
    output logic [DATA_W-1:0] tx_out_tdata,
    output logic              tx_out_tvalid,
    output logic              tx_out_tlast,
    input  logic              tx_out_tready,
    input  logic [DATA_W-1:0] rx_in_tdata,
    input  logic              rx_in_tvalid,
    input  logic              rx_in_tlast,
    output logic              rx_in_tready,
    output logic [DATA_W-1:0] rx_out_tdata,
    output logic              rx_out_tvalid,
    output logic              rx_out_tlast,
    input  logic              rx_out_tready,
    input  logic              lnk_chan_up,
    input  logic              lnk_lane_up,
    input  logic              lnk_hard_err,
    input  logic              lnk_soft_err,
    input  logic              lnk_frame_err,
    input  logic              lnk_hotplug_exp,
    output logic              lnk_loopback,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata
);
    ctrl_t             ctrl;
    stat_t             stat_in, stat_q;
    logic [CNT_W-1:0]  cnt_in, cnt_out;
    logic              rx_done, tx_done;
    logic [DATA_W-1:0] rx_seq;

    always_comb begin
        stat_in.chan_up     = lnk_chan_up;
        stat_in.lane_up     = lnk_lane_up;
        stat_in.hard_err    = lnk_hard_err;
        stat_in.soft_err    = lnk_soft_err;
        stat_in.frame_err   = lnk_frame_err;
        stat_in.hotplug_exp = lnk_hotplug_exp;
    end

    assign lnk_loopback = ctrl.loopback;

    seqh_rx_path #(.DATA_W(DATA_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .seq_off    (ctrl.seq_off),
        .strip      (ctrl.strip),
        .in_tdata   (rx_in_tdata),
        .in_tvalid  (rx_in_tvalid),
        .in_tlast   (rx_in_tlast),
        .in_tready  (rx_in_tready),
        .out_tdata  (rx_out_tdata),
        .out_tvalid (rx_out_tvalid),
        .out_tlast  (rx_out_tlast),
        .out_tready (rx_out_tready),
        .frame_done (rx_done),
        .last_seq   (rx_seq)
    );

    seqh_tx_path #(.DATA_W(DATA_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .seq_off    (ctrl.seq_off),
        .echo       (ctrl.echo),
        .rx_seq     (rx_seq),
        .in_tdata   (tx_in_tdata),
        .in_tvalid  (tx_in_tvalid),
        .in_tlast   (tx_in_tlast),
        .in_tready  (tx_in_tready),
        .out_tdata  (tx_out_tdata),
        .out_tvalid (tx_out_tvalid),
        .out_tlast  (tx_out_tlast),
        .out_tready (tx_out_tready),
        .frame_done (tx_done)
    );

    seqh_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wen   (reg_wen),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .stat_in   (stat_in),
        .frame_in  (rx_done),
        .frame_out (tx_done),
        .ctrl      (ctrl),
        .stat_q    (stat_q),
        .cnt_in    (cnt_in),
        .cnt_out   (cnt_out)
    );
endmodule

// File: rtl/seqh_checker.sv
module seqh_checker
    import seqh_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wen,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  reg_rdata,
    input stat_t             stat_in,
    input stat_t             stat_q,
    input logic [CNT_W-1:0]  cnt_in,
    input logic [CNT_W-1:0]  cnt_out,
    input logic              rx_in_tvalid,
    input logic              rx_in_tready,
    input logic              rx_in_tlast,
    input logic              tx_out_tvalid,
    input logic              tx_out_tready,
    input logic              tx_out_tlast
);
    logic clr_wr, known_addr;
    assign clr_wr = reg_wen && (reg_addr == OFS_CTRL) && reg_wdata[1];
    assign known_addr = (reg_addr == OFS_STATUS) || (reg_addr == OFS_CTRL) ||
                        (reg_addr == OFS_IN_LO)  || (reg_addr == OFS_IN_HI) ||
                        (reg_addr == OFS_OUT_HI) || (reg_addr == OFS_OUT_LO);

    AST_STATUS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (stat_q == $past(stat_in))) else $error("status latch"); // R2

    AST_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> (cnt_in == '0) && (cnt_out == '0)) else $error("counter clear"); // R4

    AST_IN_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_in_tvalid && rx_in_tready && rx_in_tlast && !clr_wr)
        |=> (cnt_in == $past(cnt_in) + CNT_W'(1))) else $error("incoming count"); // R5

    AST_OUT_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_out_tvalid && tx_out_tready && tx_out_tlast && !clr_wr)
        |=> (cnt_out == $past(cnt_out) + CNT_W'(1))) else $error("outgoing count"); // R6

    AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !known_addr |-> (reg_rdata == '0)) else $error("undefined offset"); // R12

    AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_STATUS) |-> (reg_rdata[REG_W-1:STAT_W] == '0)) else $error("status upper"); // R2
endmodule

bind seq_frame_handler seqh_checker u_seqh_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_addr      (reg_addr),
    .reg_wen       (reg_wen),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .stat_in       (stat_in),
    .stat_q        (stat_q),
    .cnt_in        (cnt_in),
    .cnt_out       (cnt_out),
    .rx_in_tvalid  (rx_in_tvalid),
    .rx_in_tready  (rx_in_tready),
    .rx_in_tlast   (rx_in_tlast),
    .tx_out_tvalid (tx_out_tvalid),
    .tx_out_tready (tx_out_tready),
    .tx_out_tlast  (tx_out_tlast)
);

// File: tb/test_seq_frame_handler.sv
module test_seq_frame_handler;
    localparam int CLK_P = 10;
    localparam int DW    = 32;
    localparam int WD_CYCLES = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DW-1:0] tx_in_tdata = '0, tx_out_tdata, rx_in_tdata = '0, rx_out_tdata;
    logic tx_in_tvalid = 0, tx_in_tlast = 0, tx_in_tready;
    logic tx_out_tvalid, tx_out_tlast, tx_out_tready = 1;
    logic rx_in_tvalid = 0, rx_in_tlast = 0, rx_in_tready;
    logic rx_out_tvalid, rx_out_tlast, rx_out_tready = 1;
    logic [5:0] lnk_st = '0;
    logic lnk_loopback;
    logic [4:0] reg_addr = '0;
    logic reg_wen = 0;
    logic [31:0] reg_wdata = '0, reg_rdata;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [DW-1:0] gen_exp = '0, seq_exp = '0;
    logic [63:0] cin_exp = '0, cout_exp = '0;
    logic [DW-1:0] wds [8];
    logic [DW-1:0] got_d [16];
    bit got_l [16];

    always #(CLK_P/2) clk = ~clk;

    seq_frame_handler #(.DATA_W(DW)) i_seq_frame_handler (
        .clk(clk), .rst_n(rst_n),
        .tx_in_tdata(tx_in_tdata), .tx_in_tvalid(tx_in_tvalid), .tx_in_tlast(tx_in_tlast), .tx_in_tready(tx_in_tready),
        .tx_out_tdata(tx_out_tdata), .tx_out_tvalid(tx_out_tvalid), .tx_out_tlast(tx_out_tlast), .tx_out_tready(tx_out_tready),
        .rx_in_tdata(rx_in_tdata), .rx_in_tvalid(rx_in_tvalid), .rx_in_tlast(rx_in_tlast), .rx_in_tready(rx_in_tready),
        .rx_out_tdata(rx_out_tdata), .rx_out_tvalid(rx_out_tvalid), .rx_out_tlast(rx_out_tlast), .rx_out_tready(rx_out_tready),
        .lnk_chan_up(lnk_st[0]), .lnk_lane_up(lnk_st[1]), .lnk_hard_err(lnk_st[2]),
        .lnk_soft_err(lnk_st[3]), .lnk_frame_err(lnk_st[4]), .lnk_hotplug_exp(lnk_st[5]),
        .lnk_loopback(lnk_loopback),
        .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ctrl_word(input bit loopb, input bit off, input bit strp, input bit ech);
        return {27'd0, ech, strp, off, 1'b0, loopb};
    endfunction

    task automatic reg_wr(input logic [4:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic reg_rd(input logic [4:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    // frame received from the link; seq_off/strip are the options the frame is expected to see
    task automatic run_rx(input int n, input bit off, input bit strp, input bit bub, input string tag);
        int idx = 0, gotn = 0, guard = 0, exp_n, bad = 0;
        bit fin = 0;
        for (int i = 0; i < n; i++) wds[i] = $urandom;
        while (!fin && guard < 300) begin
            @(negedge clk);
            rx_in_tvalid  = (idx < n) && (!bub || ($urandom % 4 != 0));
            rx_in_tdata   = (idx < n) ? wds[idx] : '0;
            rx_in_tlast   = (idx == n - 1);
            rx_out_tready = !bub || ($urandom % 3 != 0);
            #1;
            if (rx_out_tvalid && rx_out_tready && gotn < 16) begin
                got_d[gotn] = rx_out_tdata; got_l[gotn] = rx_out_tlast; gotn++;
            end
            if (rx_in_tvalid && rx_in_tready) begin
                if (rx_in_tlast) fin = 1;
                idx++;
            end
            guard++;
        end
        @(negedge clk);
        rx_in_tvalid = 0; rx_out_tready = 1;
        exp_n = (!off && strp) ? n - 1 : n;
        for (int i = 0; i < gotn && i < exp_n; i++)
            if (got_d[i] != wds[i] || got_l[i] != (i == exp_n - 1)) bad++;
        chk(gotn == exp_n && bad == 0, tag, 64'(gotn * 256 + bad), 64'(exp_n * 256));
        cin_exp++;
        if (!off) seq_exp = wds[n-1];
    endtask

    // frame sent from the host; expected trailing word from the bench model
    task automatic run_tx(input int n, input bit off, input bit ech, input bit bub, input string tag);
        int idx = 0, gotn = 0, guard = 0, exp_n, bad = 0;
        bit fin = 0;
        logic [DW-1:0] sq;
        for (int i = 0; i < n; i++) wds[i] = $urandom;
        sq = ech ? seq_exp : gen_exp;
        if (!off) wds[n] = sq;
        exp_n = off ? n : n + 1;
        while (!fin && guard < 300) begin
            @(negedge clk);
            tx_in_tvalid  = (idx < n) && (!bub || ($urandom % 4 != 0));
            tx_in_tdata   = (idx < n) ? wds[idx] : '0;
            tx_in_tlast   = (idx == n - 1);
            tx_out_tready = !bub || ($urandom % 3 != 0);
            #1;
            if (tx_out_tvalid && tx_out_tready) begin
                if (gotn < 16) begin
                    got_d[gotn] = tx_out_tdata; got_l[gotn] = tx_out_tlast; gotn++;
                end
                if (tx_out_tlast) fin = 1;
            end
            if (tx_in_tvalid && tx_in_tready) idx++;
            guard++;
        end
        @(negedge clk);
        tx_in_tvalid = 0; tx_out_tready = 1;
        for (int i = 0; i < gotn && i < exp_n; i++)
            if (got_d[i] != wds[i] || got_l[i] != (i == exp_n - 1)) bad++;
        chk(gotn == exp_n && bad == 0, tag, 64'(gotn * 256 + bad), 64'(exp_n * 256));
        if (!off && gotn > 0) chk(got_d[gotn-1] == sq, {tag, " trailing word"}, 64'(got_d[gotn-1]), 64'(sq));
        cout_exp++;
        if (!off && !ech) gen_exp++;
    endtask

    task automatic check_counts(input string tag);
        logic [31:0] lo, hi;
        reg_rd(5'h08, lo); reg_rd(5'h0C, hi);
        chk({hi, lo} == cin_exp, {tag, " R5 incoming count"}, {hi, lo}, cin_exp);
        reg_rd(5'h1C, lo); reg_rd(5'h18, hi);
        chk({hi, lo} == cout_exp, {tag, " R6 outgoing count"}, {hi, lo}, cout_exp);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int m;
        bit lb, off, strp, ech;
        void'($urandom(32'd1234));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 32; a += 4) begin
            reg_rd(5'(a), v);
            chk(v == 0, "R1 reset register", v, 0);
        end
        chk(lnk_loopback == 0 && !rx_out_tvalid && !tx_out_tvalid, "R1 reset outputs",
            {lnk_loopback, rx_out_tvalid, tx_out_tvalid}, 0);

        // R2 status register latency and layout
        @(negedge clk);
        lnk_st = 6'b101101;
        reg_rd(5'h00, v);
        chk(v == 0, "R2 status before edge", v, 0);
        @(negedge clk);
        reg_rd(5'h00, v);
        chk(v == 32'h2D, "R2 status after edge", v, 32'h2D);
        lnk_st = 6'b010010;
        @(negedge clk);
        reg_rd(5'h00, v);
        chk(v == 32'h12, "R2 status second pattern", v, 32'h12);

        // R3 control read-back and loopback output
        reg_wr(5'h04, 32'hFFFF_FFFD);
        reg_rd(5'h04, v);
        chk(v == 32'h1D, "R3 control readback", v, 32'h1D);
        chk(lnk_loopback == 1, "R3 loopback output", lnk_loopback, 1);
        reg_wr(5'h04, 32'h0);
        reg_rd(5'h04, v);
        chk(v == 0 && lnk_loopback == 0, "R3 control cleared", v, 0);

        // R10 echo before any capture sends 0
        reg_wr(5'h04, ctrl_word(0, 0, 0, 1));
        run_tx(3, 0, 1, 0, "R10 echo before capture");
        // R9 generated count starts at 0 and steps
        reg_wr(5'h04, ctrl_word(0, 0, 0, 0));
        run_tx(2, 0, 0, 0, "R9 first generated");
        run_tx(1, 0, 0, 1, "R9 second generated");
        // R7 bypass with strip and echo set
        reg_wr(5'h04, ctrl_word(0, 1, 1, 1));
        run_rx(4, 1, 1, 1, "R7 bypass receive");
        run_tx(4, 1, 1, 1, "R7 bypass transmit");
        // R8 strip, including a one-word frame
        reg_wr(5'h04, ctrl_word(0, 0, 1, 0));
        run_rx(5, 0, 1, 0, "R8 strip frame");
        run_rx(1, 0, 1, 1, "R8 one-word strip frame");
        // R10 echo of captured word
        reg_wr(5'h04, ctrl_word(0, 0, 1, 1));
        run_tx(2, 0, 1, 1, "R10 echo captured");
        check_counts("directed");

        // R11 control change inside a frame applies at next frame
        reg_wr(5'h04, ctrl_word(0, 0, 1, 0));
        fork
            run_rx(6, 0, 1, 0, "R11 strip kept mid-frame");
            begin
                repeat (2) @(negedge clk);
                reg_wr(5'h04, ctrl_word(0, 1, 0, 0));
            end
        join
        run_rx(3, 1, 0, 0, "R11 bypass from next frame");

        // random mix of modes
        for (int it = 0; it < 60; it++) begin
            m = $urandom % 5;
            lb = 1'($urandom);
            off = (m == 0); strp = (m == 1 || m == 4); ech = (m == 3 || m == 4);
            if (m == 0) begin strp = 1'($urandom); ech = 1'($urandom); end
            reg_wr(5'h04, ctrl_word(lb, off, strp, ech));
            run_rx(1 + $urandom % 6, off, strp, 1, "R8 R7 random receive");
            run_tx(1 + $urandom % 6, off, ech, 1, ech ? "R10 random transmit" : "R9 random transmit");
        end
        check_counts("random");

        // R4 counter clear and one-cycle flag
        reg_wr(5'h04, ctrl_word(1, 0, 0, 0) | 32'h2);
        reg_rd(5'h04, v);
        chk(v == 32'h3, "R4 clear flag set", v, 32'h3);
        cin_exp = 0; cout_exp = 0;
        check_counts("R4 after clear");
        @(negedge clk);
        reg_rd(5'h04, v);
        chk(v == 32'h1, "R4 clear flag self-clears", v, 32'h1);
        run_tx(2, 0, 0, 0, "R9 after clear");
        check_counts("R4 count resumes");

        // R12 undefined offsets
        for (int a = 1; a < 32; a++) begin
            if (a != 4 && a != 8 && a != 12 && a != 24 && a != 28) begin
                reg_rd(5'(a), v);
                chk(v == 0, "R12 undefined offset", v, 0);
            end
        end

        done = 1;
        summary();
        $finish;
    end
endmodule